// File: doc/BRIEF.md
# Timer Interrupt and Carry Control

This block is the control glue that sits beside three external 16-bit interval counters. It owns a small global control register with three live bits: one enables the periodic interrupt, and two chain the counters together so that the output of a higher-numbered counter drives the count of the next lower one. It generates the base count enable by dividing the system clock, and it steers either that base enable or a carry pulse to each counter's clock-enable output.

The counter 0 output drives an interrupt latch. The latch is a two-state machine with states `LATCH_IDLE` and `LATCH_PEND`. It takes the transition `IDLE->PEND` on a synchronised rising edge of counter 0 while interrupts are enabled. It takes the transition `PEND->IDLE` on a clear-strobe write, unless a new edge arrives in that same cycle. Otherwise it holds. A 4-bit interrupt level register gates the interrupt request pin, and the value 0 means the interrupt is not used. A status read returns the latch and the three synchronised counter outputs.

Top module: `tmr_irq_glue`

## Requirements
- R1: After reset the control register, level register and latch are 0. `irq` is low. With `cnt_out` low, a status read returns 0x00.
- R2: A `glb_wr` write loads `wr_data[2]` as interrupt enable, `wr_data[1]` as the counter 2 to counter 1 link, and `wr_data[0]` as the counter 1 to counter 0 link. Bits 7..3 have no effect, so writing 0xF8 leaves interrupts and links off.
- R3: `cnt_ce[2]` is a one-cycle base pulse that recurs every DIV (default 14) clock cycles. The first pulse comes in the DIV-th cycle after reset is released.
- R4: When a link is off, the lower counter of that link receives the base pulse, so `cnt_ce[1]` and `cnt_ce[0]` equal `cnt_ce[2]`.
- R5: When a link is on, the lower counter's enable is a one-cycle pulse on each rising edge of the higher counter's output. The pulse is seen after the second clock edge that follows the input change. No base pulses reach that counter.
- R6: A rising edge on `cnt_out[0]` sets the latch only while interrupt enable is 1. The latch is set at the third clock edge after the input change.
- R7: While `stat_rd` is high, `rd_data` is {latch, 4'b0000, synchronised `cnt_out[2:0]`}. The counter bits lag the input by two clock edges. While `stat_rd` is low, `rd_data` is 0x00.
- R8: A `clr_wr` strobe clears the latch at that edge, whatever the value of `wr_data`. Until that clear, the latch stays set.
- R9: If a clear strobe and a set edge fall in the same cycle, the latch ends up set.
- R10: `irq` follows the latch while the level register (loaded from `wr_data[3:0]` by `lvl_wr`) is nonzero. It is held low while the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Write data byte |
| glb_wr | input | 1 | Global control write strobe |
| lvl_wr | input | 1 | Interrupt level write strobe |
| clr_wr | input | 1 | Clear-interrupt write strobe |
| stat_rd | input | 1 | Status read select |
| rd_data | output | 8 | Status byte |
| cnt_out | input | 3 | Outputs of counters 2..0 (asynchronous) |
| cnt_ce | output | 3 | Count enables for counters 2..0 |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge that samples the strobe and are visible from the following half cycle. Counter outputs appear in the status byte and as carry pulses after the second edge following the change. The latch and `irq` respond after the third edge. The bench drives inputs 1 ns after a rising edge. It advances its behavioural model on the rising edge and compares all outputs on every falling edge, so each result is checked exactly in the cycle it becomes due. The directed checks then wait the same fixed number of edges before sampling the interrupt, status and carry outputs.

// File: rtl/tmr_glue_pkg.sv
package tmr_glue_pkg;

    localparam int NCNT = 3;

    typedef enum logic {
        LATCH_IDLE = 1'b0,
        LATCH_PEND = 1'b1
    } latch_st_e;

    // field order follows the written byte: bit 2, bit 1, bit 0
    typedef struct packed {
        logic ien;
        logic lnk21;
        logic lnk10;
    } glb_ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic base_tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign base_tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (base_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R3
    base_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> !base_tick);

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < DIV);

endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] q,
    output logic [N-1:0] rise
);
    logic [N-1:0] q_prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sh <= '0;
            else
                sh <= {sh[STAGES-1:0], din[i]};
        end
        assign q[i]      = sh[STAGES-1];
        assign q_prev[i] = sh[STAGES];
    end

    assign rise = q & ~q_prev;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R5
        rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch
    import tmr_glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic pend
);
    latch_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= LATCH_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LATCH_IDLE: if (set_ev) st_d = LATCH_PEND;
            LATCH_PEND: if (clr && !set_ev) st_d = LATCH_IDLE;
            default:    st_d = LATCH_IDLE;
        endcase
    end

    always_comb begin
        pend = (st_q == LATCH_PEND);
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> pend);

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_ev) |=> !pend);

    // R8
    hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

endmodule

// File: rtl/tmr_irq_glue.sv
module tmr_irq_glue
    import tmr_glue_pkg::*;
#(
    parameter int DIV   = 14,
    parameter int LVL_W = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wr_data,
    input  logic          glb_wr,
    input  logic          lvl_wr,
    input  logic          clr_wr,
    input  logic          stat_rd,
    output logic [DW-1:0] rd_data,
    input  logic [2:0]    cnt_out,
    output logic [2:0]    cnt_ce,
    output logic          irq
);
    localparam int PAD_W = DW - NCNT - 1;

    glb_ctrl_t         ctrl_q;
    logic [LVL_W-1:0]  lvl_q;
    logic              base_tick;
    logic [NCNT-1:0]   cnt_s;
    logic [NCNT-1:0]   cnt_rise;
    logic [1:0]        lnk_v;
    logic              pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (glb_wr) ctrl_q <= glb_ctrl_t'(wr_data[NCNT-1:0]);
            if (lvl_wr) lvl_q  <= wr_data[LVL_W-1:0];
        end
    end

    tmr_prescale #(.DIV(DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick)
    );

    tmr_sync #(.N(NCNT), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnt_out),
        .q     (cnt_s),
        .rise  (cnt_rise)
    );

    tmr_irq_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (cnt_rise[0] & ctrl_q.ien),
        .clr    (clr_wr),
        .pend   (pend)
    );

    assign lnk_v = {ctrl_q.lnk21, ctrl_q.lnk10};

    // each lower counter takes the carry of the next one or the base pulse
    for (genvar i = 0; i < 2; i++) begin : g_route
        assign cnt_ce[i] = lnk_v[i] ? cnt_rise[i+1] : base_tick;
    end
    assign cnt_ce[2] = base_tick;

    assign rd_data = stat_rd ? {pend, {PAD_W{1'b0}}, cnt_s} : '0;
    assign irq     = pend & (lvl_q != '0);

    // R10
    lvl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == '0) |-> !irq);

    // R6
    set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(ctrl_q.ien));

    // R4
    unlinked_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.lnk10 |-> (cnt_ce[0] == cnt_ce[2]));

    // R5
    linked_no_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.lnk21 && cnt_ce[1]) |-> $rose(cnt_s[2]));

endmodule

// File: tb/sim_tmr_irq_glue.sv
module sim_tmr_irq_glue;
    localparam int DIV = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic       glb_wr = 1'b0, lvl_wr = 1'b0, clr_wr = 1'b0, stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] cnt_out = '0;
    logic [2:0] cnt_ce;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tmr_irq_glue #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .glb_wr(glb_wr),
        .lvl_wr(lvl_wr), .clr_wr(clr_wr), .stat_rd(stat_rd), .rd_data(rd_data),
        .cnt_out(cnt_out), .cnt_ce(cnt_ce), .irq(irq)
    );

    // behavioural reference model
    logic [2:0] hist[$] = '{3'b0, 3'b0, 3'b0};
    int         m_div = 0;
    logic [2:0] m_ctrl = '0;
    logic [3:0] m_lvl = '0;
    logic       m_latch = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b0, 3'b0, 3'b0};
            m_div = 0; m_ctrl = '0; m_lvl = '0; m_latch = 1'b0;
        end else begin
            if (hist[1][0] && !hist[0][0] && m_ctrl[2]) m_latch = 1'b1;
            else if (clr_wr) m_latch = 1'b0;
            if (glb_wr) m_ctrl = wr_data[2:0];
            if (lvl_wr) m_lvl = wr_data[3:0];
            m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
            void'(hist.pop_front());
            hist.push_back(cnt_out);
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic t;
            logic [2:0] rz;
            t  = (m_div == DIV - 1);
            rz = hist[1] & ~hist[0];
            chk("R3 ce2", {7'b0, cnt_ce[2]}, {7'b0, t});
            chk("R4 R5 ce1", {7'b0, cnt_ce[1]}, {7'b0, m_ctrl[1] ? rz[2] : t});
            chk("R4 R5 ce0", {7'b0, cnt_ce[0]}, {7'b0, m_ctrl[0] ? rz[1] : t});
            chk("R6 R10 irq", {7'b0, irq}, {7'b0, m_latch && (m_lvl != 0)});
            chk("R7 status", rd_data, stat_rd ? {m_latch, 4'b0, hist[1]} : 8'h00);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe_glb(input logic [7:0] d);
        wr_data = d; glb_wr = 1'b1; step(1); glb_wr = 1'b0;
    endtask

    task automatic strobe_lvl(input logic [7:0] d);
        wr_data = d; lvl_wr = 1'b1; step(1); lvl_wr = 1'b0;
    endtask

    task automatic strobe_clr(input logic [7:0] d);
        wr_data = d; clr_wr = 1'b1; step(1); clr_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        step(3);
        rst_n = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        chk("R1 status", rd_data, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        step(1);

        // R3: base pulse spacing
        do @(negedge clk); while (!cnt_ce[2]);
        n = 0;
        do begin @(negedge clk); n++; end while (!cnt_ce[2]);
        chk("R3 period", 8'(n), 8'(DIV));
        // R4: unlinked counters share the base pulse
        chk("R4 ce1", {7'b0, cnt_ce[1]}, 8'h01);
        chk("R4 ce0", {7'b0, cnt_ce[0]}, 8'h01);
        step(1);

        // R2: upper bits only -> interrupt stays disabled
        strobe_lvl(8'h03);
        strobe_glb(8'hF8);
        cnt_out[0] = 1'b1; step(4);
        @(negedge clk);
        chk("R2 ignored bits", rd_data, 8'h01);
        cnt_out[0] = 1'b0; step(3);

        // R6: enabled set
        strobe_glb(8'h04);
        cnt_out[0] = 1'b1; step(2);
        @(negedge clk);
        chk("R6 not yet", {7'b0, irq}, 8'h00);
        step(1);
        @(negedge clk);
        chk("R6 set", {7'b0, irq}, 8'h01);
        chk("R7 latch bit", rd_data, 8'h81);
        cnt_out[0] = 1'b0; step(3);
        @(negedge clk);
        chk("R8 held", {7'b0, irq}, 8'h01);

        // R8: clear with arbitrary data
        step(1);
        strobe_clr(8'hA5);
        @(negedge clk);
        chk("R8 cleared", rd_data, 8'h00);

        // R9: clear coinciding with set
        cnt_out[0] = 1'b1; step(3);
        cnt_out[0] = 1'b0; step(3);
        cnt_out[0] = 1'b1; step(2);
        wr_data = 8'h00; clr_wr = 1'b1; step(1); clr_wr = 1'b0;
        @(negedge clk);
        chk("R9 set wins", {7'b0, irq}, 8'h01);
        step(1);
        strobe_clr(8'h00);
        @(negedge clk);
        chk("R8 clear after", {7'b0, irq}, 8'h00);

        // R10: level gating
        step(1);
        cnt_out[0] = 1'b0; step(3);
        cnt_out[0] = 1'b1; step(3);
        strobe_lvl(8'h00);
        @(negedge clk);
        chk("R10 level 0", {7'b0, irq}, 8'h00);
        chk("R10 latch kept", {7'b0, rd_data[7]}, 8'h01);
        step(1);
        strobe_lvl(8'h05);
        @(negedge clk);
        chk("R10 level 5", {7'b0, irq}, 8'h01);
        step(1);
        strobe_clr(8'h3C);

        // R5: carry chain
        strobe_glb(8'h03);
        cnt_out = 3'b100; step(2);
        @(negedge clk);
        chk("R5 carry 2-1", {7'b0, cnt_ce[1]}, 8'h01);
        step(1);
        @(negedge clk);
        chk("R5 single pulse", {7'b0, cnt_ce[1]}, 8'h00);
        step(1);
        cnt_out = 3'b110; step(2);
        @(negedge clk);
        chk("R5 carry 1-0", {7'b0, cnt_ce[0]}, 8'h01);
        step(1);
        repeat (30) step(1);

        // mixed activity against the model
        for (int i = 0; i < 400; i++) begin
            cnt_out = 3'($urandom_range(0, 7));
            stat_rd = 1'($urandom_range(0, 1));
            wr_data = 8'($urandom);
            glb_wr  = ($urandom_range(0, 15) == 0);
            lvl_wr  = ($urandom_range(0, 31) == 0);
            clr_wr  = ($urandom_range(0, 7) == 0);
            step(1);
        end
        glb_wr = 1'b0; lvl_wr = 1'b0; clr_wr = 1'b0;
        step(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule